// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

A slave device that was cut off in the middle of a byte can keep SDA low forever, and then no controller can start a transfer. This block frees such a bus. On a start request it takes the SCL and SDA pins away from the normal controller through an override path and drives them itself. It keeps SDA released and toggles SCL nine times, which lets the stuck slave shift out whatever bits it still holds. It then produces a clean STOP condition with an explicit four-step pin sequence. Every step of the sequence lasts one fixed dwell time, which is 5 µs by default. The dwell is computed in clock cycles from the system clock frequency.

At the end the block samples SDA through a two-flop synchronizer. It raises a one-cycle done pulse and reports in a held bus_free flag whether SDA read high. The surrounding controller decides when to request a recovery. It can read bus_free afterwards to tell a successful recovery from a bus that is still busy.

Top module: `bus_unjam_seq`

## Requirements
- R1: After reset, override_en=0, scl_level=1, sda_level=1, done=0 and bus_free=0. Whenever override_en=0, both level outputs are 1.
- R2: A start sampled high while idle makes override_en=1 from the next cycle on. The first step then drives scl_level=1 and sda_level=1.
- R3: sda_level stays 1 during the whole clocking phase, which is the first 18 steps.
- R4: During the clocking phase SCL is pulsed 9 times. Each pulse is one step with scl_level=1 followed by one step with scl_level=0.
- R5: After the pulses come four STOP steps in this order, given as {scl_level,sda_level}: {0,1}, {0,0}, {1,0}, {1,1}.
- R6: Every step lasts exactly STEP_CYCLES clock cycles, where STEP_CYCLES = CLK_HZ*STEP_NS/1e9 and is at least 1. A run is 22 steps.
- R7: In the cycle after the last step, done is 1 for exactly one cycle and override_en is already 0.
- R8: bus_free takes the synchronized sda_in level at completion. It keeps that value, whatever sda_in does, until the next completion.
- R9: A start pulse while a run is in progress is ignored. The waveform and the completion time are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a recovery run (taken only when idle) |
| sda_in | input | 1 | Sensed SDA bus level (asynchronous) |
| override_en | output | 1 | 1 while the sequencer owns the pins |
| scl_level | output | 1 | SCL level to drive while overriding (1 = released) |
| sda_level | output | 1 | SDA level to drive while overriding (1 = released) |
| done | output | 1 | One-cycle pulse when a run completes |
| bus_free | output | 1 | SDA level seen at the last completion |

## Verification
Start is driven between clock edges, so the edge that samples it is edge 0. From that edge on, the output levels belong to step floor(j/STEP_CYCLES) in the cycle after edge j. The bench compares them against a bench function in every one of the 22*STEP_CYCLES cycles. done, the release of override_en and the new bus_free value are all due exactly 22*STEP_CYCLES cycles after edge 0, and they are checked in that cycle. sda_in is held for the whole run, so the two-cycle synchronizer latency cannot move the expected bus_free value. All samples are taken at the falling edge.

// File: rtl/unjam_pkg.sv
package unjam_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SCL_HI = 3'd1,
    PH_SCL_LO = 3'd2,
    PH_STOP_1 = 3'd3,
    PH_STOP_2 = 3'd4,
    PH_STOP_3 = 3'd5,
    PH_STOP_4 = 3'd6
  } phase_e;
endpackage

// File: rtl/unjam_rst_sync.sv
module unjam_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/unjam_sda_sync.sv
module unjam_sda_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '1;
    else        ff_q <= {ff_q[STAGES-2:0], d_async};
  end

  assign d_sync = ff_q[STAGES-1];
endmodule

// File: rtl/unjam_step_timer.sv
module unjam_step_timer #(
  parameter int STEP_CYCLES = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(STEP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = run && (cnt_q == LAST);
  assign cnt_en = clear || run;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bus_unjam_seq.sv
module bus_unjam_seq
  import unjam_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int STEP_NS     = 5000,
  parameter int PULSES      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sda_in,
  output logic override_en,
  output logic scl_level,
  output logic sda_level,
  output logic done,
  output logic bus_free
);
  localparam longint STEP_RAW    = (longint'(CLK_HZ) * longint'(STEP_NS)) / 64'd1_000_000_000;
  localparam int     STEP_CYCLES = (STEP_RAW < 1) ? 1 : int'(STEP_RAW);
  localparam int     PW          = $clog2(PULSES + 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSES - 1);

  logic    rst_sn;
  logic    sda_s;
  logic    tick;
  logic    launch;
  phase_e  phase_q, phase_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic    done_d;
  logic    done_q;
  logic    free_q;

  unjam_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_sn)
  );

  unjam_sda_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_sn), .d_async(sda_in), .d_sync(sda_s)
  );

  assign launch = start && (phase_q == PH_IDLE);

  unjam_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sn), .clear(launch),
    .run(phase_q != PH_IDLE), .tick(tick)
  );

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    pulse_d = pulse_q;
    done_d  = 1'b0;
    if (launch) begin
      phase_d = PH_SCL_HI;
      pulse_d = '0;
    end else if (tick) begin
      unique case (phase_q)
        PH_SCL_HI: phase_d = PH_SCL_LO;
        PH_SCL_LO: begin
          if (pulse_q == PULSE_LAST) phase_d = PH_STOP_1;
          else begin
            phase_d = PH_SCL_HI;
            pulse_d = pulse_q + 1'b1;
          end
        end
        PH_STOP_1: phase_d = PH_STOP_2;
        PH_STOP_2: phase_d = PH_STOP_3;
        PH_STOP_3: phase_d = PH_STOP_4;
        PH_STOP_4: begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
        default:   phase_d = PH_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q <= PH_IDLE;
      pulse_q <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pulse_q <= pulse_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     free_q <= 1'b0;
    else if (done_d) free_q <= sda_s;
  end

  // pin levels per phase
  always_comb begin
    scl_level = 1'b1;
    sda_level = 1'b1;
    unique case (phase_q)
      PH_SCL_LO: scl_level = 1'b0;
      PH_STOP_1: scl_level = 1'b0;
      PH_STOP_2: begin scl_level = 1'b0; sda_level = 1'b0; end
      PH_STOP_3: sda_level = 1'b0;
      default: ;
    endcase
  end

  assign override_en = (phase_q != PH_IDLE);
  assign done        = done_q;
  assign bus_free    = free_q;

  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    !override_en |-> (scl_level && sda_level));

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (start && !override_en) |=> (override_en && scl_level && sda_level));

  assert_step_hold_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (override_en && !tick) |=> $stable(phase_q));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> !override_en);

  assert_free_hold_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    !done |-> $stable(bus_free));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (override_en && start && !tick) |=> $stable(phase_q));
endmodule

// File: tb/bus_unjam_seq_tb.sv
module bus_unjam_seq_tb;
  localparam int STEP  = 5;            // 125 MHz, 40 ns step
  localparam int STEPS = 22;
  localparam int TOTAL = STEPS * STEP;

  logic clk = 1'b0;
  logic rst_n, start, sda_in;
  logic override_en, scl_level, sda_level, done, bus_free;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  always #4 clk = ~clk;

  bus_unjam_seq #(.CLK_HZ(125_000_000), .STEP_NS(40)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sda_in(sda_in),
    .override_en(override_en), .scl_level(scl_level), .sda_level(sda_level),
    .done(done), .bus_free(bus_free)
  );

  function automatic logic [1:0] exp_pins(int step);
    if (step < 18)  return {~step[0], 1'b1};   // R3 R4
    case (step)
      18: return 2'b01;                         // R5
      19: return 2'b00;
      20: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_check(string tag);
    check(tag, {4'b0, override_en, scl_level, sda_level, done}, 8'b0000_0110);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle_check("R1 reset state");
    check("R1 bus_free reset", {7'b0, bus_free}, 8'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("R1 after release");
  endtask

  task automatic run_once(logic sda_val, int spur_at);
    @(negedge clk);
    sda_in = sda_val;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < TOTAL; j++) begin
      logic [1:0] e;
      e = exp_pins(j / STEP);
      if (j == 0) check("R2 first step", {5'b0, override_en, scl_level, sda_level}, {5'b0, 1'b1, e});
      else check("R3 R4 R5 R6 R9 pins", {5'b0, override_en, scl_level, sda_level},
                 {5'b0, 1'b1, e});
      check("R7 no early done", {7'b0, done}, 8'd0);
      start = (j == spur_at);
      @(negedge clk);
    end
    start = 1'b0;
    check("R7 completion", {5'b0, override_en, done, 1'b0}, 8'b0000_0010);
    check("R8 bus_free value", {7'b0, bus_free}, {7'b0, sda_val});
    @(negedge clk);
    check("R7 done one cycle", {7'b0, done}, 8'd0);
    sda_in = ~sda_val;
    repeat (4) @(negedge clk);
    check("R8 bus_free held", {7'b0, bus_free}, {7'b0, sda_val});
    idle_check("R1 idle between runs");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; sda_in = 1'b1;
    do_reset();
    run_once(1'b1, -1);
    run_once(1'b0, 0);             // R9 spurious start right after launch
    run_once(1'b1, TOTAL - 2);     // R9 spurious start in last step
    run_once(1'b0, -1);
    for (int k = 0; k < 12; k++) begin
      int sp;
      sp = ($urandom % 2 == 0) ? -1 : int'($urandom % (TOTAL - 1));
      run_once(1'($urandom % 2), sp);
    end
    // reset in the middle of a run: R1
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (37) @(negedge clk);
    do_reset();
    run_once(1'b1, -1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule